// File: doc/BRIEF.md
# Multiplexed Two-Digit Seconds Counter

This block keeps a running count of seconds from 00 to 59 and shows it on a pair of seven-segment displays. Both displays share one set of segment lines, and the block lights only one of them at a time. A prescaler turns the master clock into square waves at 4 kHz, 2 kHz and 1 kHz, and then into a 1 Hz square wave. Each of these waves is brought out on a pin so that the time base can be observed and calibrated.

All of the logic runs in the master clock domain. The divider makes single-cycle enable pulses, and these pulses advance the BCD count and flip the digit select. None of the derived waves is used as a clock. A parameter sets the polarity of the segment and digit-enable outputs. Three more parameters set the master clock rate, the base rate and the number of 1 kHz periods in one second. With these, a small test configuration keeps the same ratios between stages.

Top module: `sec_counter_top`

## Requirements
- R1: `sq_4k` is a square wave. It toggles once every CLK_HZ/(2*BASE_HZ) master clock cycles. After reset its first toggle, from 0 to 1, comes at the end of the first such interval.
- R2: `sq_2k` toggles each time `sq_4k` falls, and `sq_1k` toggles each time `sq_2k` falls. Each stage therefore halves the rate of the stage before it, and both start at 0 after reset.
- R3: `sq_1hz` is low for the first SEC_DIV/2 periods of `sq_1k` in every second and high for the remaining periods. One second is SEC_DIV periods of `sq_1k`, each measured from one falling edge of `sq_1k` to the next.
- R4: The units digit advances by one at the falling edge of `sq_1k` that ends each second, and holds at all other times. It goes from 9 back to 0, and that step adds one to the tens digit.
- R5: The tens digit only takes the values 0 to 5. The tick that moves the display from 59 returns both digits to 00.
- R6: The digit select changes at every falling edge of `sq_1k`. `dig_en[0]` lights the units digit and `dig_en[1]` lights the tens digit, and exactly one of the two is active at any time.
- R7: `seg` bit 0 is segment a and bit 6 is segment g, and it shows the digit that is currently selected. In active-high form the codes for 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. BCD codes 10 to 15 give a blank pattern.
- R8: With ACTIVE_HIGH = 0, `seg` and `dig_en` are the bitwise inverse of the patterns that the active-high build gives for the same cycle.
- R9: While `rst` is high at a clock edge, both digits, all divider counters and all square waves are cleared, and the units digit is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sq_4k | output | 1 | Base-rate square wave |
| sq_2k | output | 1 | Base rate divided by 2 |
| sq_1k | output | 1 | Base rate divided by 4 |
| sq_1hz | output | 1 | Seconds square wave |
| seg | output | 7 | Segments a (bit 0) to g (bit 6), shared by both digits |
| dig_en | output | 2 | One-hot digit enables, bit 0 units, bit 1 tens |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any checking starts, so that every `$past` value comes from a reset state. They also assume that the parameters give a prescale interval of at least one cycle and an even SEC_DIV. The bench holds reset across several edges at the start and again in the middle of the run. It changes `rst` only on falling clock edges and builds the design with a prescale of 8 cycles and a 10-period second, so that a full wrap from 59 to 00 happens well inside the run. A second instance with inverted polarity runs side by side with the first, so the two polarities are compared on every cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int BCD_W = 4;
    localparam int SEG_W = 7;
    localparam int NUM_DIGITS = 2;
    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [NUM_DIGITS-1:0] en_t;
endpackage

// File: rtl/sc_divider.sv
module sc_divider #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BASE_HZ = 4000,
    parameter int SEC_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic sq_4k,
    output logic sq_2k,
    output logic sq_1k,
    output logic sq_1hz,
    output logic ms_tick,
    output logic sec_tick
);
    localparam int HALF  = CLK_HZ / (2 * BASE_HZ);
    localparam int PRE_W = $clog2(HALF + 1);
    localparam int SEC_W = $clog2(SEC_DIV + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(HALF - 1);
    localparam logic [SEC_W-1:0] MS_LAST  = SEC_W'(SEC_DIV - 1);
    localparam logic [SEC_W-1:0] MS_HALF  = SEC_W'(SEC_DIV / 2);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             q4;
        logic             q2;
        logic             q1;
        logic [SEC_W-1:0] ms;
    } div_state_t;

    div_state_t st_d, st_q;
    logic half_tick;

    always_comb begin
        st_d      = st_q;
        half_tick = (st_q.pre == PRE_LAST);
        ms_tick   = half_tick & st_q.q4 & st_q.q2 & st_q.q1;
        sec_tick  = ms_tick & (st_q.ms == MS_LAST);
        if (half_tick) begin
            st_d.pre = '0;
            st_d.q4  = ~st_q.q4;
            if (st_q.q4) begin
                st_d.q2 = ~st_q.q2;
                if (st_q.q2) begin
                    st_d.q1 = ~st_q.q1;
                end
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        if (ms_tick) begin
            st_d.ms = sec_tick ? '0 : st_q.ms + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sq_4k  = st_q.q4;
    assign sq_2k  = st_q.q2;
    assign sq_1k  = st_q.q1;
    assign sq_1hz = (st_q.ms >= MS_HALF);
endmodule

// File: rtl/sc_bcd_count.sv
module sc_bcd_count
    import sc_pkg::*;
#(
    parameter int UNITS_MAX = 9,
    parameter int TENS_MAX  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output bcd_t units,
    output bcd_t tens
);
    localparam bcd_t U_LAST = BCD_W'(UNITS_MAX);
    localparam bcd_t T_LAST = BCD_W'(TENS_MAX);

    typedef struct packed {
        bcd_t units;
        bcd_t tens;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.units == U_LAST) begin
                st_d.units = '0;
                st_d.tens  = (st_q.tens == T_LAST) ? '0 : st_q.tens + 1'b1;
            end else begin
                st_d.units = st_q.units + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign units = st_q.units;
    assign tens  = st_q.tens;
endmodule

// File: rtl/sc_digit_mux.sv
module sc_digit_mux
    import sc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flip,
    input  bcd_t units,
    input  bcd_t tens,
    output logic sel,
    output bcd_t digit,
    output en_t  en_raw
);
    typedef struct packed {
        logic sel;
    } mux_state_t;

    mux_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flip) begin
            st_d.sel = ~st_q.sel;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel    = st_q.sel;
    assign digit  = st_q.sel ? tens : units;
    assign en_raw = st_q.sel ? en_t'(2'b10) : en_t'(2'b01);
endmodule

// File: rtl/sc_seg_decode.sv
module sc_seg_decode
    import sc_pkg::*;
(
    input  bcd_t digit,
    output seg_t pattern
);
    always_comb begin
        case (digit)
            4'd0:    pattern = 7'h3F;
            4'd1:    pattern = 7'h06;
            4'd2:    pattern = 7'h5B;
            4'd3:    pattern = 7'h4F;
            4'd4:    pattern = 7'h66;
            4'd5:    pattern = 7'h6D;
            4'd6:    pattern = 7'h7D;
            4'd7:    pattern = 7'h07;
            4'd8:    pattern = 7'h7F;
            4'd9:    pattern = 7'h6F;
            default: pattern = 7'h00;
        endcase
    end
endmodule

// File: rtl/sec_counter_top.sv
module sec_counter_top
    import sc_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BASE_HZ     = 4000,
    parameter int SEC_DIV     = 1000,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    output logic       sq_4k,
    output logic       sq_2k,
    output logic       sq_1k,
    output logic       sq_1hz,
    output logic [6:0] seg,
    output logic [1:0] dig_en
);
    logic ms_tick, sec_tick, sel;
    bcd_t units_q, tens_q, digit;
    en_t  en_raw;
    seg_t seg_raw;

    sc_divider #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .SEC_DIV(SEC_DIV)) u_div (
        .clk(clk), .rst(rst),
        .sq_4k(sq_4k), .sq_2k(sq_2k), .sq_1k(sq_1k), .sq_1hz(sq_1hz),
        .ms_tick(ms_tick), .sec_tick(sec_tick)
    );

    sc_bcd_count #(.UNITS_MAX(9), .TENS_MAX(5)) u_cnt (
        .clk(clk), .rst(rst), .step(sec_tick),
        .units(units_q), .tens(tens_q)
    );

    sc_digit_mux u_mux (
        .clk(clk), .rst(rst), .flip(ms_tick),
        .units(units_q), .tens(tens_q),
        .sel(sel), .digit(digit), .en_raw(en_raw)
    );

    sc_seg_decode u_dec (
        .digit(digit), .pattern(seg_raw)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pos
            assign seg    = seg_raw;
            assign dig_en = en_raw;
        end else begin : g_neg
            assign seg    = ~seg_raw;
            assign dig_en = ~en_raw;
        end
    endgenerate
endmodule

// File: rtl/sc_checker.sv
module sc_checker
    import sc_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic       sec_tick,
    input bcd_t       units,
    input bcd_t       tens,
    input logic       sel,
    input logic       sq_4k,
    input logic       sq_2k,
    input logic       sq_1k,
    input logic [1:0] dig_en
);
    logic [1:0] en_ah;
    always_comb en_ah = ACTIVE_HIGH ? dig_en : ~dig_en;

    // R9: reset state
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (units == 4'd0 && tens == 4'd0 && sel == 1'b0));

    // R2: divider stages toggle only on the fall of the previous stage
    p_2k_on_4k_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sq_2k) |-> $fell(sq_4k));
    p_1k_on_2k_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sq_1k) |-> $fell(sq_2k));

    // R4: units digit range, hold and carry
    p_units_range_r4: assert property (@(posedge clk) disable iff (rst)
        units <= 4'd9);
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> ($stable(units) && $stable(tens)));
    p_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && units == 4'd9 && tens != 4'd5) |=>
            (units == 4'd0 && tens == $past(tens) + 4'd1));

    // R5: tens range and full wrap
    p_tens_range_r5: assert property (@(posedge clk) disable iff (rst)
        tens <= 4'd5);
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && units == 4'd9 && tens == 4'd5) |=>
            (units == 4'd0 && tens == 4'd0));

    // R6: digit select and one-hot enables
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> $stable(sel));
    p_sel_flip_r6: assert property (@(posedge clk) disable iff (rst)
        ms_tick |=> (sel != $past(sel)));
    p_onehot_en_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(en_ah) == 1);
endmodule

bind sec_counter_top sc_checker #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .sec_tick(sec_tick),
    .units(units_q), .tens(tens_q), .sel(sel),
    .sq_4k(sq_4k), .sq_2k(sq_2k), .sq_1k(sq_1k), .dig_en(dig_en)
);

// File: tb/tb_sec_counter_top.sv
module tb_sec_counter_top;
    localparam int CLK_HZ  = 64000;
    localparam int BASE_HZ = 4000;
    localparam int SEC_DIV = 10;
    localparam int HALF    = CLK_HZ / (2 * BASE_HZ);
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sq_4k, sq_2k, sq_1k, sq_1hz;
    logic [6:0] seg;
    logic [1:0] dig_en;
    logic i4k, i2k, i1k, i1hz;
    logic [6:0] iseg;
    logic [1:0] ien;

    int n = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sec_counter_top #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .SEC_DIV(SEC_DIV),
                      .ACTIVE_HIGH(1'b1)) dut (
        .clk(clk), .rst(rst), .sq_4k(sq_4k), .sq_2k(sq_2k), .sq_1k(sq_1k),
        .sq_1hz(sq_1hz), .seg(seg), .dig_en(dig_en)
    );

    sec_counter_top #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .SEC_DIV(SEC_DIV),
                      .ACTIVE_HIGH(1'b0)) dut_inv (
        .clk(clk), .rst(rst), .sq_4k(i4k), .sq_2k(i2k), .sq_1k(i1k),
        .sq_1hz(i1hz), .seg(iseg), .dig_en(ien)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
            4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
            8: pat = 7'h7F; 9: pat = 7'h6F; default: pat = 7'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at n=%0d: actual 0x%0h expected 0x%0h", req, n, act, exp);
        end
    endtask

    // Cycle model: n edges since reset release
    always @(posedge clk) begin
        if (rst) n = 0;
        else n = n + 1;
    end

    task automatic check_cycle(input bit in_reset);
        int t, ms, secs, d;
        bit sel;
        logic [6:0] e_seg;
        logic [1:0] e_en;
        string tag;
        t    = n / HALF;
        ms   = t / 8;
        secs = (ms / SEC_DIV) % 60;
        sel  = ms[0];
        d    = sel ? secs / 10 : secs % 10;
        e_seg = pat(d);
        e_en  = sel ? 2'b10 : 2'b01;
        if (in_reset) begin
            check(sq_4k == 0 && sq_2k == 0 && sq_1k == 0 && sq_1hz == 0 &&
                  seg == 7'h3F && dig_en == 2'b01, "R9",
                  {sq_4k, sq_2k, sq_1k, sq_1hz, seg, dig_en}, {4'b0, 7'h3F, 2'b01});
            return;
        end
        check(sq_4k == t[0], "R1", sq_4k, t[0]);
        check({sq_2k, sq_1k} == {t[1], t[2]}, "R2", {sq_2k, sq_1k}, {t[1], t[2]});
        check(sq_1hz == ((ms % SEC_DIV) >= SEC_DIV / 2), "R3", sq_1hz,
              (ms % SEC_DIV) >= SEC_DIV / 2);
        check(dig_en == e_en, "R6", dig_en, e_en);
        // R4 units path, R5 wrap after 59, R7 tens path/encoding
        if (ms >= 60 * SEC_DIV && secs < 2) tag = "R5";
        else if (!sel) tag = "R4";
        else tag = "R7";
        check(seg == e_seg, tag, seg, e_seg);
        check(iseg == ~e_seg && ien == ~e_en, "R8", {iseg, ien}, {~e_seg, ~e_en});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at n=%0d actual 0 expected 1", n);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check_cycle(1'b1);
        rst = 1'b0;
        // over one full wrap 59 -> 00 plus a few seconds
        repeat (HALF * 8 * SEC_DIV * 62) begin
            @(negedge clk);
            check_cycle(1'b0);
        end
        // mid-run reset (R9)
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_cycle(1'b1);
        end
        rst = 1'b0;
        repeat (HALF * 8 * SEC_DIV * 3) begin
            @(negedge clk);
            check_cycle(1'b0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule